// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This block forms the second operand of a 32-bit data-processing operation. It receives a 12-bit operand-control field together with the value of the chosen source register, the value of the shift-amount register, the current carry flag and a set-flags enable. It returns the shifted operand and the carry-out that the ALU uses when it updates its flags. The control field also gives the register indices, which the block passes back out so that the caller knows which registers to read.

The unit has five operations: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry. The shift amount comes either from a 5-bit immediate in the control field or from the low byte of a register. An immediate of zero means something different for each shift type. Register amounts of the word width or more follow their own rules for the result and for the carry.

The unit is purely combinational. The caller supplies every register value, including any program-counter substitution.

Top module: `bsh_operand`

## Requirements
- R1: Field positions in the control field: bits [3:0] are the source register index and appear on `src_idx`. Bits [6:4] are the shift kind. Bits [11:7] are the immediate amount. Bits [11:8] are the amount-register index and appear on `amt_idx`. The kind values are 0 LSL-imm, 1 LSL-reg, 2 LSR-imm, 3 LSR-reg, 4 ASR-imm, 5 ASR-reg, 6 ROR-imm, 7 ROR-reg. Kind bit 0 set means a register amount, and it appears on `amt_from_reg`.
- R2: A register amount uses only bits [7:0] of `amt_reg_val`. Bits [31:8] have no effect on any output.
- R3: For LSL by immediate, an amount of 0 passes the value through and keeps the carry. An amount n of 1..31 gives the value shifted left by n, with carry-out equal to input bit 32-n.
- R4: For LSR by immediate, an amount n of 1..31 gives a logical right shift with carry-out equal to input bit n-1. An amount of 0 means a shift by 32, which gives a result of zero and carry-out equal to input bit 31.
- R5: For ASR by immediate, an amount n of 1..31 sign-extends, with carry-out equal to input bit n-1. An amount of 0 means 32: every result bit and the carry-out equal input bit 31.
- R6: For ROR by immediate, an amount n of 1..31 rotates right, with carry-out equal to input bit n-1. An amount of 0 selects rotate-through-carry: the result is {carry_in, input[31:1]} and carry-out is input bit 0.
- R7: A register amount of 0 returns the input unchanged and keeps the carry, for all four register kinds.
- R8: For LSL by register, amounts 1..31 behave as in R3. An amount of 32 gives a result of zero with carry-out equal to input bit 0. An amount above 32 gives zero for both the result and the carry.
- R9: For LSR by register, amounts 1..31 behave as in R4. An amount of 32 gives a result of zero with carry-out equal to input bit 31. An amount above 32 gives zero for both the result and the carry.
- R10: For ASR by register, amounts 1..31 behave as in R5. An amount of 32 or more fills the result with input bit 31 and sets carry-out to input bit 31.
- R11: For ROR by register, the rotation is by the amount modulo 32, with carry-out equal to result bit 31. A nonzero amount whose low five bits are zero leaves the value unchanged, with carry-out equal to input bit 31.
- R12: When `set_flags` is 0, `carry_out` equals `carry_in` whatever the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_field | input | 12 | Operand-control field |
| src_val | input | 32 | Value of the source register |
| amt_reg_val | input | 32 | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Carry-out follows the shifter when high |
| src_idx | output | 4 | Source register index from the field |
| amt_idx | output | 4 | Amount-register index from the field |
| amt_from_reg | output | 1 | High when the amount comes from a register |
| shifted | output | 32 | Shifted operand |
| carry_out | output | 1 | Carry for the flag update |

## Verification
The bench sweeps every immediate amount and every low-byte register amount for all eight kinds. It uses six data words chosen so that the sign bit, bit 0 and the bits in between differ, and it tries every combination of carry-in and set-flags.

The bench targets the cases where an amount of zero is reinterpreted. If the LSR-imm or ASR-imm zero case were not mapped to 32, the design would pass the value through. If the RRX case were missing, the design would return the input instead of shifting in the old carry.

At the boundaries of 32 and 33, a design that clamps the amount too early would give the wrong carry. Examples are an LSL of 32 with carry zero instead of bit 0, or an LSR above 32 with carry bit 31 instead of zero. Upper bits of the amount register are filled with noise, so a design that decodes more than the low byte would shift to zero on small amounts.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  // internal operation after amount interpretation
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5
  } bsh_op_e;

  // shift family held in kind bits [2:1]
  typedef enum logic [1:0] {
    FAM_LSL = 2'd0,
    FAM_LSR = 2'd1,
    FAM_ASR = 2'd2,
    FAM_ROR = 2'd3
  } bsh_fam_e;

  // 3-bit kind: family in the upper two bits, register-amount flag in bit 0
  typedef struct packed {
    bsh_fam_e fam;
    logic     by_reg;
  } bsh_kind_t;

endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
  import bsh_pkg::*;
#(
  parameter int unsigned CTL_W = 12,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned IMM_W = 5
) (
  input  logic [CTL_W-1:0] ctl,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] amt_idx,
  output bsh_kind_t        kind,
  output logic [IMM_W-1:0] imm
);
  localparam int unsigned KIND_LO = IDX_W;
  localparam int unsigned IMM_LO  = CTL_W - IMM_W;
  localparam int unsigned AIDX_LO = CTL_W - IDX_W;

  assign src_idx = ctl[IDX_W-1:0];
  assign kind    = bsh_kind_t'(ctl[KIND_LO +: 3]);
  assign imm     = ctl[IMM_LO +: IMM_W];
  assign amt_idx = ctl[AIDX_LO +: IDX_W];
endmodule

// File: rtl/bsh_amount.sv
module bsh_amount
  import bsh_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IMM_W = 5,
  parameter int unsigned AMT_W = 8
) (
  input  bsh_kind_t        kind,
  input  logic [IMM_W-1:0] imm,
  input  logic [AMT_W-1:0] reg_amt,
  output bsh_op_e          op,
  output logic [AMT_W-1:0] amt
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DW);

  logic                 imm_zero;
  logic [AMT_W-1:0]     imm_ext;

  assign imm_zero = (imm == '0);
  assign imm_ext  = AMT_W'(imm);

  always_comb begin
    op  = OP_PASS;
    amt = '0;
    if (kind.by_reg) begin
      amt = reg_amt;
      if (reg_amt != '0) begin
        unique case (kind.fam)
          FAM_LSL: op = OP_LSL;
          FAM_LSR: op = OP_LSR;
          FAM_ASR: op = OP_ASR;
          default: op = OP_ROR;
        endcase
      end
    end else begin
      unique case (kind.fam)
        FAM_LSL: begin
          if (!imm_zero) begin
            op  = OP_LSL;
            amt = imm_ext;
          end
        end
        FAM_LSR: begin
          op  = OP_LSR;
          amt = imm_zero ? FULL : imm_ext;
        end
        FAM_ASR: begin
          op  = OP_ASR;
          amt = imm_zero ? FULL : imm_ext;
        end
        default: begin
          op  = imm_zero ? OP_RRX : OP_ROR;
          amt = imm_ext;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AMT_W = 8
) (
  input  bsh_op_e          op,
  input  logic [AMT_W-1:0] amt,
  input  logic [DW-1:0]    x,
  input  logic             cin,
  output logic [DW-1:0]    res,
  output logic             cres
);
  localparam int unsigned SW = $clog2(DW);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DW);

  // each returns {carry, result}
  function automatic logic [DW:0] f_lsl(input logic [DW-1:0] v, input logic [AMT_W-1:0] n);
    logic [DW:0] t;
    t = {1'b0, v} << n;
    return t;
  endfunction

  function automatic logic [DW:0] f_lsr(input logic [DW-1:0] v, input logic [AMT_W-1:0] n);
    logic [DW:0] t;
    t = {v, 1'b0} >> n;
    return {t[0], t[DW:1]};
  endfunction

  function automatic logic [DW:0] f_asr(input logic [DW-1:0] v, input logic [AMT_W-1:0] n);
    logic signed [DW:0] t;
    logic [AMT_W-1:0]   nc;
    nc = (n > FULL) ? FULL : n;
    t  = $signed({v, 1'b0}) >>> nc;
    return {t[0], t[DW:1]};
  endfunction

  function automatic logic [DW:0] f_ror(input logic [DW-1:0] v, input logic [AMT_W-1:0] n);
    logic [2*DW-1:0] d;
    logic [SW-1:0]   m;
    m = n[SW-1:0];
    d = {v, v} >> m;
    return {d[DW-1], d[DW-1:0]};
  endfunction

  function automatic logic [DW:0] f_rrx(input logic [DW-1:0] v, input logic c);
    return {v[0], c, v[DW-1:1]};
  endfunction

  always_comb begin
    unique case (op)
      OP_LSL:  {cres, res} = f_lsl(x, amt);
      OP_LSR:  {cres, res} = f_lsr(x, amt);
      OP_ASR:  {cres, res} = f_asr(x, amt);
      OP_ROR:  {cres, res} = f_ror(x, amt);
      OP_RRX:  {cres, res} = f_rrx(x, cin);
      default: {cres, res} = {cin, x};
    endcase
  end
endmodule

// File: rtl/bsh_operand.sv
module bsh_operand
  import bsh_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CTL_W = 12,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned IMM_W = 5,
  parameter int unsigned AMT_W = 8
) (
  input  logic [CTL_W-1:0] ctl_field,
  input  logic [DW-1:0]    src_val,
  input  logic [DW-1:0]    amt_reg_val,
  input  logic             carry_in,
  input  logic             set_flags,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] amt_idx,
  output logic             amt_from_reg,
  output logic [DW-1:0]    shifted,
  output logic             carry_out
);
  bsh_kind_t        kind;
  logic [IMM_W-1:0] imm;
  bsh_op_e          op;
  logic [AMT_W-1:0] amt;
  logic             raw_carry;

  // named events for the checker
  logic pass_thru;
  logic rrx_sel;

  bsh_decode #(.CTL_W(CTL_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
    .ctl     (ctl_field),
    .src_idx (src_idx),
    .amt_idx (amt_idx),
    .kind    (kind),
    .imm     (imm)
  );

  bsh_amount #(.DW(DW), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .kind    (kind),
    .imm     (imm),
    .reg_amt (amt_reg_val[AMT_W-1:0]),
    .op      (op),
    .amt     (amt)
  );

  bsh_core #(.DW(DW), .AMT_W(AMT_W)) u_core (
    .op   (op),
    .amt  (amt),
    .x    (src_val),
    .cin  (carry_in),
    .res  (shifted),
    .cres (raw_carry)
  );

  assign amt_from_reg = kind.by_reg;
  assign pass_thru    = (op == OP_PASS);
  assign rrx_sel      = (op == OP_RRX);
  assign carry_out    = set_flags ? raw_carry : carry_in;
endmodule

// File: rtl/bsh_operand_checks.sv
module bsh_operand_checks #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CTL_W = 12,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned IMM_W = 5,
  parameter int unsigned AMT_W = 8
) (
  input logic [CTL_W-1:0] ctl_field,
  input logic [DW-1:0]    src_val,
  input logic [DW-1:0]    amt_reg_val,
  input logic             carry_in,
  input logic             set_flags,
  input logic [DW-1:0]    shifted,
  input logic             carry_out,
  input logic             pass_thru,
  input logic             rrx_sel
);
  localparam int unsigned SW = $clog2(DW);

  logic [2:0]       k;
  logic [IMM_W-1:0] im;
  logic [AMT_W-1:0] ra;

  assign k  = ctl_field[IDX_W +: 3];
  assign im = ctl_field[CTL_W-IMM_W +: IMM_W];
  assign ra = amt_reg_val[AMT_W-1:0];

  always_comb begin
    a_r12_carry_hold: assert (set_flags || carry_out == carry_in);
    a_r7_pass_value: assert (!pass_thru || (shifted == src_val && carry_out == carry_in));
    a_r7_reg_zero: assert (!(k[0] && ra == '0) || (shifted == src_val && carry_out == carry_in));
    a_r3_lsl_imm_zero: assert (!(k == 3'd0 && im == '0) || (shifted == src_val && carry_out == carry_in));
    a_r4_lsr_imm_full: assert (!(k == 3'd2 && im == '0) ||
                               (shifted == '0 && (!set_flags || carry_out == src_val[DW-1])));
    a_r6_rrx_fill: assert (!rrx_sel ||
                           (shifted == {carry_in, src_val[DW-1:1]} && (!set_flags || carry_out == src_val[0])));
    a_r9_lsr_over: assert (!(k == 3'd3 && ra > AMT_W'(DW)) || (shifted == '0 && !(set_flags && carry_out)));
    a_r10_asr_over: assert (!(k == 3'd5 && ra >= AMT_W'(DW)) ||
                            (shifted == {DW{src_val[DW-1]}} && (!set_flags || carry_out == src_val[DW-1])));
    a_r11_ror_wrap: assert (!(k == 3'd7 && ra != '0 && ra[SW-1:0] == '0) ||
                            (shifted == src_val && (!set_flags || carry_out == src_val[DW-1])));
  end
endmodule

bind bsh_operand bsh_operand_checks #(
  .DW(DW), .CTL_W(CTL_W), .IDX_W(IDX_W), .IMM_W(IMM_W), .AMT_W(AMT_W)
) u_chk (
  .ctl_field   (ctl_field),
  .src_val     (src_val),
  .amt_reg_val (amt_reg_val),
  .carry_in    (carry_in),
  .set_flags   (set_flags),
  .shifted     (shifted),
  .carry_out   (carry_out),
  .pass_thru   (pass_thru),
  .rrx_sel     (rrx_sel)
);

// File: tb/bsh_operand_test.sv
module bsh_operand_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ctl_field = '0;
  logic [31:0] src_val = '0;
  logic [31:0] amt_reg_val = '0;
  logic        carry_in = 1'b0;
  logic        set_flags = 1'b0;
  logic [3:0]  src_idx, amt_idx;
  logic        amt_from_reg;
  logic [31:0] shifted;
  logic        carry_out;

  int n_checks = 0;
  int n_errs   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  bsh_operand uut (
    .ctl_field(ctl_field), .src_val(src_val), .amt_reg_val(amt_reg_val),
    .carry_in(carry_in), .set_flags(set_flags), .src_idx(src_idx),
    .amt_idx(amt_idx), .amt_from_reg(amt_from_reg), .shifted(shifted),
    .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input int p);
    case (p)
      0: return 32'h8000_0001;
      1: return 32'h7FFF_FFFE;
      2: return 32'hDEAD_BEEF;
      3: return 32'h1234_5678;
      4: return 32'h0000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // bit-by-bit reference of a shift of amount n >= 1
  task automatic ref_shift(input int fam, input int n, input logic [31:0] x,
                           output logic [31:0] r, output logic c);
    r = '0;
    c = 1'b0;
    for (int i = 0; i < 32; i++) begin
      case (fam)
        0: r[i] = (i >= n) ? x[i-n] : 1'b0;
        1: r[i] = (i + n < 32) ? x[i+n] : 1'b0;
        2: r[i] = (i + n < 32) ? x[i+n] : x[31];
        default: r[i] = x[(i + (n % 32)) % 32];
      endcase
    end
    case (fam)
      0: c = (n <= 32) ? x[32-n] : 1'b0;
      1: c = (n <= 32) ? x[n-1] : 1'b0;
      2: c = (n <= 32) ? x[n-1] : x[31];
      default: c = x[((n % 32) + 31) % 32];
    endcase
  endtask

  task automatic model(input logic [11:0] ctl, input logic [31:0] x, input logic [31:0] rv,
                       input logic cin, input logic sf,
                       output logic [31:0] er, output logic ec, output string tag);
    int kind = int'(ctl[6:4]);
    int imm  = int'(ctl[11:7]);
    int fam  = kind / 2;
    int n;
    er = x;
    ec = cin;
    if (ctl[4]) begin
      n = int'(rv[7:0]);
      if (n == 0) tag = "R7 R2";
      else begin
        ref_shift(fam, n, x, er, ec);
        case (fam)
          0: tag = "R8 R2";
          1: tag = "R9 R2";
          2: tag = "R10 R2";
          default: tag = "R11 R2";
        endcase
      end
    end else begin
      case (fam)
        0: begin
          tag = "R3";
          if (imm != 0) ref_shift(0, imm, x, er, ec);
        end
        1: begin
          tag = "R4";
          ref_shift(1, (imm == 0) ? 32 : imm, x, er, ec);
        end
        2: begin
          tag = "R5";
          ref_shift(2, (imm == 0) ? 32 : imm, x, er, ec);
        end
        default: begin
          tag = "R6";
          if (imm == 0) begin
            er = {cin, x[31:1]};
            ec = x[0];
          end else ref_shift(3, imm, x, er, ec);
        end
      endcase
    end
    if (!sf) begin
      ec = cin;
      tag = {tag, " R12"};
    end
  endtask

  task automatic run_one(input logic [11:0] ctl, input logic [31:0] x, input logic [31:0] rv,
                         input logic cin, input logic sf);
    logic [31:0] er;
    logic        ec;
    string       tag;
    @(posedge clk);
    ctl_field   <= ctl;
    src_val     <= x;
    amt_reg_val <= rv;
    carry_in    <= cin;
    set_flags   <= sf;
    @(negedge clk);
    model(ctl, x, rv, cin, sf, er, ec, tag);
    n_checks++;
    if (shifted !== er || carry_out !== ec) begin
      n_errs++;
      $display("FAIL %s ctl=%h x=%h rv=%h cin=%b sf=%b: actual %h/%b expected %h/%b",
               tag, ctl, x, rv, cin, sf, shifted, carry_out, er, ec);
    end
    n_checks++;
    if (src_idx !== ctl[3:0] || amt_idx !== ctl[11:8] || amt_from_reg !== ctl[4]) begin
      n_errs++;
      $display("FAIL R1 ctl=%h: actual %h/%h/%b expected %h/%h/%b",
               ctl, src_idx, amt_idx, amt_from_reg, ctl[3:0], ctl[11:8], ctl[4]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (shifted !== 32'h0 || carry_out !== 1'b0) begin
      n_errs++;
      $display("FAIL R12 idle state: actual %h/%b expected 00000000/0", shifted, carry_out);
    end

    // immediate kinds: every amount
    for (int kk = 0; kk < 4; kk++)
      for (int im = 0; im < 32; im++)
        for (int p = 0; p < 6; p++)
          for (int cs = 0; cs < 4; cs++)
            run_one({5'(im), 3'(kk * 2), 4'(p * 2 + 1)}, pat(p), 32'h0,
                    cs[0], cs[1]);

    // register kinds: every low byte, noisy upper bits (R2)
    for (int kk = 0; kk < 4; kk++)
      for (int rn = 0; rn < 256; rn++)
        for (int p = 0; p < 6; p++)
          for (int cs = 0; cs < 4; cs++)
            run_one({4'(p + 3), 1'(p), 3'(kk * 2 + 1), 4'(p * 2)}, pat(p),
                    {pat(p + 1)[31:8] ^ 24'h5A_5A5A, 8'(rn)}, cs[0], cs[1]);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule